// File: doc/BRIEF.md
# Radio Transceiver Start-Up Sequencer

This block brings an attached radio transceiver from power-up to an operational state without software help. Once its own reset is released it holds the transceiver's hardware reset pin low for a programmable number of clock cycles. It then releases the pin and waits a second programmable interval. After that it plays out a fixed, ordered list of nineteen register writes through a simple request port. A separate serial access engine consumes those requests and reports when each write has finished on the wire.

The write list is bracketed by a restart of the radio section. A restart pulse is written at the start, before any configuration. A second one is written at the end, so that the new settings take effect. The list mixes writes to the short register space and the long register space. Each entry carries a space-select bit, a register address and a data byte. When the final write is acknowledged, `init_done` rises and stays high. A `start` pulse given after completion runs the whole procedure again, beginning with the hardware reset pulse.

Top module: `xcvr_boot_seq`

## Requirements
- R1: After reset release, and after an accepted relaunch, `hw_rst_n` is low for exactly `RST_LOW_CYCLES` clock cycles and then goes high; it is low while `rst_n` is asserted.
- R2: After `hw_rst_n` rises, exactly `RST_SETTLE_CYCLES` cycles pass before `acc_valid` is first raised, and `acc_valid` is never high while `hw_rst_n` is low.
- R3: `wake` is high at all times; `csn_hold` (1 = chip select forced inactive) is high during the reset pulse, the settle wait and after completion, and low whenever a request is outstanding.
- R4: A raised `acc_valid` stays high, with `acc_long`, `acc_addr` and `acc_data` unchanged, until a cycle in which `acc_ready` is high; in the following cycle `acc_valid` is low.
- R5: After a request is accepted, no further request is raised until `acc_done` has been seen high.
- R6: The writes are issued in this exact order, where `acc_long`=0 selects the short space and 1 the long space (address, then data, in hex): S36←04, S36←00, S36←00, S01←AA, S02←AA, S03←AA, S04←AA, S0D←01, L202←80, L203←00, L206←80, L208←10, S3A←78, S3E←40, S3F←00, L200←00, S00←01, S36←04, S36←00.
- R7: `init_done` rises in the cycle after `acc_done` is seen for the last write. It then stays high until `rst_n` is asserted or a relaunch is accepted.
- R8: A `start` pulse while `init_done` is high clears `init_done` and replays R1, R2 and the full list of R6.
- R9: `start` while the sequence is still running is ignored: `hw_rst_n` stays high and the list continues from where it was.
- R10: `acc_done` seen while no accepted request is waiting for it has no effect. This covers the settle wait and cycles with `acc_valid` high. The list is not advanced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Relaunch request, honoured only after completion |
| hw_rst_n | output | 1 | Transceiver hardware reset, active low |
| wake | output | 1 | Transceiver wake pin, held high |
| csn_hold | output | 1 | 1 forces the serial chip select inactive |
| acc_valid | output | 1 | Write request to the access engine |
| acc_long | output | 1 | 0 = short address space, 1 = long address space |
| acc_addr | output | ADDR_W | Register address |
| acc_data | output | DATA_W | Byte to write |
| acc_ready | input | 1 | Access engine accepts the request this cycle |
| acc_done | input | 1 | Access engine finished the accepted write |
| init_done | output | 1 | Whole sequence complete |

## Verification
The hardest situations to reach are the ones where the control inputs arrive at the wrong moment. One is a `start` pulse in the middle of the write list. Another is a completion strobe that arrives while nothing is waiting for it. The bench models the access engine with varying ready and done latencies. It injects a stray `acc_done` during the settle wait and during request cycles with `acc_ready` held low. It pulses `start` after the fifth write of the relaunched run. The scoreboard then shows that the list neither skips nor restarts, and the pin timing is measured cycle by cycle on both the power-up run and the relaunch.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

   localparam int unsigned OP_ADDR_W = 10;
   localparam int unsigned OP_DATA_W = 8;
   localparam int unsigned SEQ_LEN   = 19;

   typedef struct packed {
      logic                 is_long;
      logic [OP_ADDR_W-1:0] addr;
      logic [OP_DATA_W-1:0] data;
   } wr_op_t;

   typedef enum logic [2:0] {
      ST_HWRST  = 3'd0,
      ST_SETTLE = 3'd1,
      ST_ISSUE  = 3'd2,
      ST_AWAIT  = 3'd3,
      ST_READY  = 3'd4
   } seq_state_t;

   function automatic wr_op_t mk_op(input logic lng, input logic [OP_ADDR_W-1:0] a,
                                    input logic [OP_DATA_W-1:0] d);
      wr_op_t o;
      o.is_long = lng;
      o.addr    = a;
      o.data    = d;
      return o;
   endfunction

   // Fixed start-up list; order is behaviour (RF restart brackets the configuration).
   function automatic wr_op_t op_at(input int unsigned idx);
      case (idx)
         0:  return mk_op(1'b0, 10'h036, 8'h04);
         1:  return mk_op(1'b0, 10'h036, 8'h00);
         2:  return mk_op(1'b0, 10'h036, 8'h00);
         3:  return mk_op(1'b0, 10'h001, 8'hAA);
         4:  return mk_op(1'b0, 10'h002, 8'hAA);
         5:  return mk_op(1'b0, 10'h003, 8'hAA);
         6:  return mk_op(1'b0, 10'h004, 8'hAA);
         7:  return mk_op(1'b0, 10'h00D, 8'h01);
         8:  return mk_op(1'b1, 10'h202, 8'h80);
         9:  return mk_op(1'b1, 10'h203, 8'h00);
         10: return mk_op(1'b1, 10'h206, 8'h80);
         11: return mk_op(1'b1, 10'h208, 8'h10);
         12: return mk_op(1'b0, 10'h03A, 8'h78);
         13: return mk_op(1'b0, 10'h03E, 8'h40);
         14: return mk_op(1'b0, 10'h03F, 8'h00);
         15: return mk_op(1'b1, 10'h200, 8'h00);
         16: return mk_op(1'b0, 10'h000, 8'h01);
         17: return mk_op(1'b0, 10'h036, 8'h04);
         18: return mk_op(1'b0, 10'h036, 8'h00);
         default: return '0;
      endcase
   endfunction

endpackage

// File: rtl/xbs_tick_counter.sv
module xbs_tick_counter #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   output logic [WIDTH-1:0] count
);

   localparam logic [WIDTH-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count <= '0;
      else if (clear)            count <= '0;
      else if (count != CNT_MAX) count <= count + 1'b1;
   end

endmodule

// File: rtl/xbs_step_counter.sv
module xbs_step_counter #(
   parameter int unsigned STEPS = 19,
   localparam int unsigned W    = (STEPS > 1) ? $clog2(STEPS) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         advance,
   output logic [W-1:0] idx,
   output logic         last
);

   localparam logic [W-1:0] LAST_IDX = W'(STEPS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 idx <= '0;
      else if (clear)             idx <= '0;
      else if (advance && !last)  idx <= idx + 1'b1;
   end

   assign last = (idx == LAST_IDX);

   // R6: the step index never leaves the list
   a_r6_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= LAST_IDX);

endmodule

// File: rtl/xbs_step_rom.sv
module xbs_step_rom
   import xbs_pkg::*;
#(
   parameter int unsigned IDX_W = 5
) (
   input  logic [IDX_W-1:0] idx,
   output wr_op_t           op
);

   always_comb op = op_at(int'(idx));

endmodule

// File: rtl/xcvr_boot_seq.sv
module xcvr_boot_seq
   import xbs_pkg::*;
#(
   parameter int unsigned RST_LOW_CYCLES    = 20000,
   parameter int unsigned RST_SETTLE_CYCLES = 20000,
   parameter int unsigned ADDR_W            = 10,
   parameter int unsigned DATA_W            = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              hw_rst_n,
   output logic              wake,
   output logic              csn_hold,
   output logic              acc_valid,
   output logic              acc_long,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [DATA_W-1:0] acc_data,
   input  logic              acc_ready,
   input  logic              acc_done,
   output logic              init_done
);

   localparam int unsigned MAX_WAIT = (RST_LOW_CYCLES > RST_SETTLE_CYCLES) ?
                                      RST_LOW_CYCLES : RST_SETTLE_CYCLES;
   localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);
   localparam int unsigned STEP_W   = $clog2(SEQ_LEN);
   localparam logic [CNT_W-1:0] LOW_LAST    = CNT_W'(RST_LOW_CYCLES - 1);
   localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(RST_SETTLE_CYCLES - 1);

   generate
      if (RST_LOW_CYCLES < 1) begin : g_bad_low
         $error("RST_LOW_CYCLES must be at least 1");
      end
      if (RST_SETTLE_CYCLES < 1) begin : g_bad_settle
         $error("RST_SETTLE_CYCLES must be at least 1");
      end
      if (ADDR_W < OP_ADDR_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the long register space");
      end
      if (DATA_W < OP_DATA_W) begin : g_bad_data
         $error("DATA_W too narrow for a register byte");
      end
   endgenerate

   seq_state_t        state_q, state_d;
   logic [CNT_W-1:0]  tick;
   logic [STEP_W-1:0] step;
   logic              step_last;
   wr_op_t            cur_op;

   xbs_tick_counter #(.WIDTH(CNT_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state_d != state_q),
      .count (tick)
   );

   xbs_step_counter #(.STEPS(SEQ_LEN)) u_step (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (state_q == ST_HWRST),
      .advance ((state_q == ST_AWAIT) && acc_done),
      .idx     (step),
      .last    (step_last)
   );

   xbs_step_rom #(.IDX_W(STEP_W)) u_rom (
      .idx (step),
      .op  (cur_op)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_HWRST:  if (tick == LOW_LAST)    state_d = ST_SETTLE;
         ST_SETTLE: if (tick == SETTLE_LAST) state_d = ST_ISSUE;
         ST_ISSUE:  if (acc_ready)           state_d = ST_AWAIT;
         ST_AWAIT:  if (acc_done)            state_d = step_last ? ST_READY : ST_ISSUE;
         ST_READY:  if (start)               state_d = ST_HWRST;
         default:                            state_d = ST_HWRST;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_HWRST;
      else        state_q <= state_d;
   end

   assign hw_rst_n  = (state_q != ST_HWRST);
   assign wake      = 1'b1;
   assign csn_hold  = (state_q != ST_ISSUE) && (state_q != ST_AWAIT);
   assign acc_valid = (state_q == ST_ISSUE);
   assign acc_long  = cur_op.is_long;
   assign acc_addr  = ADDR_W'(cur_op.addr);
   assign acc_data  = DATA_W'(cur_op.data);
   assign init_done = (state_q == ST_READY);

   // R1: the reset pulse never outlasts its programmed length
   a_r1_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HWRST) |-> (tick <= LOW_LAST));

   // R2: no request while the transceiver is held in reset
   a_r2_no_req_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_rst_n |-> !acc_valid);

   // R3: chip select is released to the engine whenever a request is up
   a_r3_csn_released: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> !csn_hold);

   // R4: request held stable until accepted
   a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_ready) |=> (acc_valid && $stable(acc_long) &&
                                     $stable(acc_addr) && $stable(acc_data)));

   // R4: request withdrawn right after acceptance
   a_r4_drop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_ready) |=> !acc_valid);

   // R5: no new request until completion is seen
   a_r5_wait_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_valid && !csn_hold && !acc_done) |=> !acc_valid);

   // R7: completion is sticky until a relaunch
   a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (init_done && !start) |=> init_done);

endmodule

// File: tb/test_xcvr_boot_seq.sv
`timescale 1ns/100ps
module test_xcvr_boot_seq;
   import xbs_pkg::*;

   localparam int unsigned LOW_C    = 40;
   localparam int unsigned SETTLE_C = 25;

   logic       clk = 1'b0;
   logic       rst_n, start;
   logic       hw_rst_n, wake, csn_hold, acc_valid, acc_long, init_done;
   logic [9:0] acc_addr;
   logic [7:0] acc_data;
   logic       eng_ready, eng_done, stray_done;
   logic       acc_done;

   int n_tests = 0;
   int n_fail  = 0;
   int n_acc   = 0;
   bit timed_out = 1'b0;
   wr_op_t exp_q[$];

   always #2.5 clk = ~clk;

   assign acc_done = eng_done | stray_done;

   xcvr_boot_seq #(
      .RST_LOW_CYCLES    (LOW_C),
      .RST_SETTLE_CYCLES (SETTLE_C),
      .ADDR_W            (10),
      .DATA_W            (8)
   ) i_xcvr_boot_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .hw_rst_n  (hw_rst_n),
      .wake      (wake),
      .csn_hold  (csn_hold),
      .acc_valid (acc_valid),
      .acc_long  (acc_long),
      .acc_addr  (acc_addr),
      .acc_data  (acc_data),
      .acc_ready (eng_ready),
      .acc_done  (acc_done),
      .init_done (init_done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Expected list written from the requirement text (R6)
   function automatic wr_op_t ref_op(input int i);
      wr_op_t o;
      logic [9:0] a;
      logic [7:0] d;
      logic       l;
      l = 1'b0;
      case (i)
         0: begin a = 10'h036; d = 8'h04; end
         1, 2: begin a = 10'h036; d = 8'h00; end
         3: begin a = 10'h001; d = 8'hAA; end
         4: begin a = 10'h002; d = 8'hAA; end
         5: begin a = 10'h003; d = 8'hAA; end
         6: begin a = 10'h004; d = 8'hAA; end
         7: begin a = 10'h00D; d = 8'h01; end
         8: begin l = 1'b1; a = 10'h202; d = 8'h80; end
         9: begin l = 1'b1; a = 10'h203; d = 8'h00; end
         10: begin l = 1'b1; a = 10'h206; d = 8'h80; end
         11: begin l = 1'b1; a = 10'h208; d = 8'h10; end
         12: begin a = 10'h03A; d = 8'h78; end
         13: begin a = 10'h03E; d = 8'h40; end
         14: begin a = 10'h03F; d = 8'h00; end
         15: begin l = 1'b1; a = 10'h200; d = 8'h00; end
         16: begin a = 10'h000; d = 8'h01; end
         17: begin a = 10'h036; d = 8'h04; end
         default: begin a = 10'h036; d = 8'h00; end
      endcase
      o.is_long = l; o.addr = a; o.data = d;
      return o;
   endfunction

   task automatic push_sequence();
      for (int i = 0; i < 19; i++) exp_q.push_back(ref_op(i));
   endtask

   // Access-engine model and scoreboard monitor
   initial begin
      wr_op_t got, want;
      int     dly;
      eng_ready = 1'b0;
      eng_done  = 1'b0;
      forever begin
         @(negedge clk);
         if (acc_valid) begin
            got = {acc_long, acc_addr, acc_data};
            dly = n_acc % 3;
            for (int k = 0; k < dly; k++) begin
               eng_done = (k == 0);   // R10: stray strobe while the request is still up
               @(negedge clk);
               eng_done = 1'b0;
               check(acc_valid && ({acc_long, acc_addr, acc_data} == got), "R4",
                     "request held before ready", {13'd0, acc_valid, acc_long, acc_addr, acc_data},
                     {13'd1, got});
            end
            eng_ready = 1'b1;
            @(negedge clk);
            eng_ready = 1'b0;
            if (exp_q.size() == 0) begin
               check(1'b0, "R6", "unexpected write", {13'd0, got}, 32'd0);
            end else begin
               want = exp_q.pop_front();
               check(got == want, "R6", "write order", {13'd0, got}, {13'd0, want});
            end
            check(!acc_valid, "R4", "valid dropped after accept", {31'd0, acc_valid}, 32'd0);
            check(!csn_hold, "R3", "csn released during write", {31'd0, csn_hold}, 32'd0);
            n_acc++;
            for (int k = 0; k < (n_acc % 4) + 1; k++) begin
               @(negedge clk);
               check(!acc_valid, "R5", "no request before done", {31'd0, acc_valid}, 32'd0);
            end
            eng_done = 1'b1;
            @(negedge clk);
            eng_done = 1'b0;
         end
      end
   end

   task automatic measure_low(output int n);
      n = 0;
      while (!hw_rst_n && n < 100000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic measure_settle(output int n);
      n = 0;
      while (!acc_valid && hw_rst_n && n < 100000) begin
         n++;
         stray_done = (n == 3);   // R10: completion strobe during the settle wait
         @(negedge clk);
      end
      stray_done = 1'b0;
   endtask

   task automatic wait_done();
      while (!init_done) @(negedge clk);
   endtask

   task automatic run_main();
      int n, base;
      rst_n = 1'b0; start = 1'b0; stray_done = 1'b0;
      push_sequence();
      repeat (3) @(negedge clk);
      check(!hw_rst_n, "R1", "hw reset low in reset", {31'd0, hw_rst_n}, 32'd0);
      check(wake && csn_hold, "R3", "wake and csn_hold in reset", {30'd0, wake, csn_hold}, 32'd3);
      check(!acc_valid && !init_done, "R7", "idle outputs in reset", {30'd0, acc_valid, init_done}, 32'd0);

      rst_n = 1'b1;
      measure_low(n);
      check(n == LOW_C, "R1", "power-up pulse length", n, LOW_C);
      check(csn_hold, "R3", "csn_hold during settle", {31'd0, csn_hold}, 32'd1);
      measure_settle(n);
      check(n == SETTLE_C, "R2", "power-up settle length", n, SETTLE_C);
      wait_done();
      check(exp_q.size() == 0, "R6", "all writes issued", exp_q.size(), 0);
      check(n_acc == 19, "R10", "stray done did not skip steps", n_acc, 19);
      check(csn_hold && wake, "R3", "pins after completion", {30'd0, csn_hold, wake}, 32'd3);
      repeat (10) @(negedge clk);
      check(init_done && !acc_valid, "R7", "done sticky, no further requests",
            {30'd0, init_done, acc_valid}, 32'd2);

      // R8: relaunch
      push_sequence();
      base  = n_acc;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(!init_done, "R8", "init_done cleared on relaunch", {31'd0, init_done}, 32'd0);
      measure_low(n);
      check(n == LOW_C, "R8", "relaunch pulse length (R1)", n, LOW_C);
      measure_settle(n);
      check(n == SETTLE_C, "R8", "relaunch settle length (R2)", n, SETTLE_C);

      // R9: start while writes are in progress
      while (n_acc < base + 5) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check(hw_rst_n && !init_done, "R9", "mid-run start ignored",
               {30'd0, hw_rst_n, init_done}, 32'd2);
      end
      wait_done();
      check(exp_q.size() == 0 && n_acc == base + 19, "R9", "list completed unchanged",
            n_acc - base, 19);

      // R7: reset clears completion
      rst_n = 1'b0;
      @(negedge clk);
      check(!init_done && !hw_rst_n, "R7", "reset clears done", {30'd0, init_done, hw_rst_n}, 32'd0);
      rst_n = 1'b1;
   endtask

   initial begin
      fork
         run_main();
         begin
            repeat (150000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) check(1'b0, "R7", "watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule